// File: doc/BRIEF.md
# Shifter-ALU Data Processing Unit

A single-cycle, purely combinational execute stage for a 32-bit processor datapath. The first operand comes from a register. The second operand comes from a register or from a zero-extended 8-bit immediate. The second operand always passes through a barrel shifter before it reaches the ALU. The shifter supports five kinds of shift. The shift amount comes either from a 5-bit field in the instruction or from the low byte of a register.

The ALU performs one of sixteen operations:
- plain and carry-chained add and subtract,
- reverse subtract with and without carry,
- four bitwise logic functions,
- two moves,
- four compare-only operations.

The unit produces N, Z, C and V flags from the result. A 4-bit condition field is tested against the incoming flags, and the result and flags are committed only when that test passes. The register file and instruction decode sit outside this block. They supply the decoded fields and consume the write-enable, the result and the next flags in the same cycle.

Top module: `dp_exec_unit`

## Requirements
- R1: When `imm_sel_i`=1, the shifter input is `imm_i` zero-extended to 32 bits. Otherwise it is `op2_reg_i`.
- R2: Shift kinds are encoded as 0=LSL, 1=LSR, 2=ASR, 3=ROR and 4=RRX (codes 5 to 7 pass the value through). For LSL, LSR and ASR:
  - An amount of 0 passes the value through, and the shifter carry equals the incoming C.
  - An amount from 1 to 31 shifts normally, and the carry is the last bit shifted out.
  - An amount of 32 gives 0 with carry bit 0 (LSL) or 0 with carry bit 31 (LSR). ASR gives the sign fill with carry equal to the sign for any amount of 32 or more.
  - An amount above 32 gives 0 with carry 0 for LSL and LSR.
- R3: For ROR:
  - An amount of 0 passes the value and carries the incoming C.
  - Any other amount rotates right by the amount modulo 32, and the carry is bit 31 of the rotated value.
  - RRX ignores the amount. It shifts right by one, inserts the incoming C at bit 31, and carries out the old bit 0.
- R4: When `shamt_sel_i`=1, the shift amount is the 8-bit `shamt_reg_i`. Otherwise it is the 5-bit `shamt_imm_i`.
- R5: Opcodes 6 to 11 compute, in this order:
  - ADD: a+b
  - ADC: a+b+C
  - SUB: a−b
  - SBC: a−b+C−1
  - RSB: b−a
  - RSC: b−a+C−1

  Here a is operand 1 and b is the shifted operand 2.
- R6: Opcodes 0 to 5 compute AND, XOR, OR, a AND NOT b, MOV b and MOV NOT b.
- R7: For arithmetic operations:
  - N is bit 31 of the result, and Z is set when the result is zero.
  - C is the carry out. For subtraction, C is the inverted borrow.
  - V is set on signed overflow.
  - Flags are packed as {N,Z,C,V} in bits 3 to 0.
- R8: For logic and move operations, C takes the shifter carry and V keeps its incoming value.
- R9: Opcodes 12 to 15 are TST (AND), TEQ (XOR), CMP (subtract) and CMN (add). They never assert `wr_en_o`. They update the flags whenever the condition passes, regardless of `s_bit_i`.
- R10: Condition codes 0 to 15 are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE, AL and NV:
  - HI means C set and Z clear.
  - GE means N equals V.
  - GT means Z clear and N equals V.
  - Each odd code from 1 to 13 is the inverse of the code below it.
  - NV never passes.

  A failed condition gives `wr_en_o`=0 and `flags_o`=`flags_i`.
- R11: For non-compare operations, the flags update only when `s_bit_i`=1 and the condition passes. Otherwise `flags_o` equals `flags_i`.
- R12: The following sequence yields the correct 64-bit sum in the two results:
  1. A flag-setting ADD of the low words.
  2. An ADC of the high words, fed the flags produced by step 1.
- R13: `shift_carry_o` always presents the shifter carry, whatever the opcode and condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition code |
| s_bit_i | input | 1 | Request flag update |
| op1_i | input | 32 | First operand |
| op2_reg_i | input | 32 | Register second operand |
| imm_i | input | 8 | Immediate second operand |
| imm_sel_i | input | 1 | Select immediate second operand |
| shift_kind_i | input | 3 | Shift kind |
| shamt_imm_i | input | 5 | Shift amount from instruction |
| shamt_reg_i | input | 8 | Shift amount from register low byte |
| shamt_sel_i | input | 1 | Select register shift amount |
| flags_i | input | 4 | Current {N,Z,C,V} |
| result_o | output | 32 | ALU result |
| wr_en_o | output | 1 | Result register write enable |
| flags_o | output | 4 | Next {N,Z,C,V} |
| shift_carry_o | output | 1 | Shifter carry out |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, an 8-bit immediate and an 8-bit register shift amount. The 8-bit amount is wider than the 5-bit log of the data width, so register-driven amounts of 32, 33 and 40 can be applied. Those values exercise the saturating LSL, LSR and ASR cases and the modulo rotation. The 32-bit width also keeps the signed-overflow boundary at 0x7FFFFFFF. The carry-chain pair therefore maps onto a 64-bit reference sum that the bench computes directly.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_ORR = 4'd2,  OP_BIC = 4'd3,
        OP_MOV = 4'd4,  OP_MVN = 4'd5,  OP_ADD = 4'd6,  OP_ADC = 4'd7,
        OP_SUB = 4'd8,  OP_SBC = 4'd9,  OP_RSB = 4'd10, OP_RSC = 4'd11,
        OP_TST = 4'd12, OP_TEQ = 4'd13, OP_CMP = 4'd14, OP_CMN = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2, SH_ROR = 3'd3, SH_RRX = 3'd4
    } shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic is_compare(alu_op_e op);
        return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC,
                          OP_CMP, OP_CMN};
    endfunction

endpackage

// File: rtl/dp_shifter.sv
module dp_shifter
    import dp_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  shift_e            kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]     sh;
    logic [DATA_W:0]     lsl_t, lsr_t, asr_t;
    logic [2*DATA_W-1:0] ror_t;
    logic                amt_zero, amt_small, amt_full;

    always_comb begin
        sh        = amt_i[SH_W-1:0];
        lsl_t     = {1'b0, val_i} << sh;
        lsr_t     = {val_i, 1'b0} >> sh;
        asr_t     = $signed({val_i, 1'b0}) >>> sh;
        ror_t     = {val_i, val_i} >> sh;
        amt_zero  = (amt_i == '0);
        amt_small = (amt_i < AMT_W'(DATA_W));
        amt_full  = (amt_i == AMT_W'(DATA_W));
    end

    always_comb begin
        res_o  = val_i;
        cout_o = cin_i;
        unique case (kind_i)
            SH_LSL: if (!amt_zero) begin
                if (amt_small)     begin res_o = lsl_t[DATA_W-1:0]; cout_o = lsl_t[DATA_W]; end
                else if (amt_full) begin res_o = '0; cout_o = val_i[0]; end
                else               begin res_o = '0; cout_o = 1'b0; end
            end
            SH_LSR: if (!amt_zero) begin
                if (amt_small)     begin res_o = lsr_t[DATA_W:1]; cout_o = lsr_t[0]; end
                else if (amt_full) begin res_o = '0; cout_o = val_i[DATA_W-1]; end
                else               begin res_o = '0; cout_o = 1'b0; end
            end
            SH_ASR: if (!amt_zero) begin
                if (amt_small) begin res_o = asr_t[DATA_W:1]; cout_o = asr_t[0]; end
                else begin
                    res_o  = {DATA_W{val_i[DATA_W-1]}};
                    cout_o = val_i[DATA_W-1];
                end
            end
            SH_ROR: if (!amt_zero) begin
                res_o  = ror_t[DATA_W-1:0];
                cout_o = ror_t[DATA_W-1];
            end
            SH_RRX: begin
                res_o  = {cin_i, val_i[DATA_W-1:1]};
                cout_o = val_i[0];
            end
            default: ;
        endcase
    end

    always_comb begin
        if (kind_i != SH_RRX && amt_i == '0)
            assert_zero_amt_pass_R2: assert (res_o == val_i && cout_o == cin_i)
                else $error("zero shift amount altered operand");
        if (kind_i == SH_RRX)
            assert_rrx_fill_R3: assert (res_o[DATA_W-1] == cin_i && cout_o == val_i[0])
                else $error("rrx fill or carry wrong");
    end

endmodule

// File: rtl/dp_cond_check.sv
module dp_cond_check
    import dp_exec_pkg::*;
(
    input  cond_e  cond_i,
    input  flags_t fl_i,
    output logic   pass_o
);
    logic base;

    always_comb begin
        unique case (cond_i[3:1])
            3'd0: base = fl_i.z;
            3'd1: base = fl_i.c;
            3'd2: base = fl_i.n;
            3'd3: base = fl_i.v;
            3'd4: base = fl_i.c & ~fl_i.z;
            3'd5: base = (fl_i.n == fl_i.v);
            3'd6: base = ~fl_i.z & (fl_i.n == fl_i.v);
            default: base = 1'b1;
        endcase
        if (cond_i == CC_NV)      pass_o = 1'b0;
        else if (cond_i == CC_AL) pass_o = 1'b1;
        else                      pass_o = cond_i[0] ? ~base : base;
    end

    always_comb begin
        if (cond_i == CC_EQ || cond_i == CC_NE)
            assert_eq_ne_R10: assert (pass_o == (fl_i.z ^ cond_i[0]))
                else $error("eq/ne decision wrong");
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  flags_t            fl_i,
    input  logic              sh_carry_i,
    output logic [DATA_W-1:0] res_o,
    output flags_t            fl_o
);
    logic [DATA_W-1:0] x, y;
    logic              ci;
    logic [DATA_W:0]   sum;
    logic              arith;

    always_comb begin
        x  = a_i;
        y  = b_i;
        ci = 1'b0;
        unique case (op_i)
            OP_ADC:         ci = fl_i.c;
            OP_SUB, OP_CMP: begin y = ~b_i; ci = 1'b1; end
            OP_SBC:         begin y = ~b_i; ci = fl_i.c; end
            OP_RSB:         begin x = b_i; y = ~a_i; ci = 1'b1; end
            OP_RSC:         begin x = b_i; y = ~a_i; ci = fl_i.c; end
            default: ;
        endcase
        sum   = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
        arith = is_arith(op_i);
    end

    always_comb begin
        unique case (op_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MOV:         res_o = b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = sum[DATA_W-1:0];
        endcase
        fl_o.n = res_o[DATA_W-1];
        fl_o.z = (res_o == '0);
        fl_o.c = arith ? sum[DATA_W] : sh_carry_i;
        fl_o.v = arith ? ((x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]))
                       : fl_i.v;
    end

    always_comb begin
        if (op_i == OP_SUB || op_i == OP_CMP)
            assert_sub_borrow_R7: assert (fl_o.c == (a_i >= b_i))
                else $error("subtract carry is not inverted borrow");
        if (op_i == OP_ADD || op_i == OP_CMN)
            assert_add_carry_R7: assert (fl_o.c == (res_o < a_i))
                else $error("add carry wrong");
    end

endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
    import dp_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int AMT_W  = 8,
    parameter int IAMT_W = $clog2(DATA_W)
) (
    input  logic [3:0]        op_i,
    input  logic [3:0]        cond_i,
    input  logic              s_bit_i,
    input  logic [DATA_W-1:0] op1_i,
    input  logic [DATA_W-1:0] op2_reg_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              imm_sel_i,
    input  logic [2:0]        shift_kind_i,
    input  logic [IAMT_W-1:0] shamt_imm_i,
    input  logic [AMT_W-1:0]  shamt_reg_i,
    input  logic              shamt_sel_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o,
    output logic              shift_carry_o
);
    alu_op_e           op;
    flags_t            fl_cur, fl_alu;
    logic [DATA_W-1:0] op2_raw, op2_sh;
    logic [AMT_W-1:0]  amt;
    logic              sh_c, pass, cmp_op, upd;

    always_comb begin
        op      = alu_op_e'(op_i);
        fl_cur  = flags_t'(flags_i);
        op2_raw = imm_sel_i ? {{(DATA_W-IMM_W){1'b0}}, imm_i} : op2_reg_i;
        amt     = shamt_sel_i ? shamt_reg_i : {{(AMT_W-IAMT_W){1'b0}}, shamt_imm_i};
    end

    dp_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
        .val_i  (op2_raw),
        .kind_i (shift_e'(shift_kind_i)),
        .amt_i  (amt),
        .cin_i  (fl_cur.c),
        .res_o  (op2_sh),
        .cout_o (sh_c)
    );

    dp_cond_check u_cond (
        .cond_i (cond_e'(cond_i)),
        .fl_i   (fl_cur),
        .pass_o (pass)
    );

    dp_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i       (op),
        .a_i        (op1_i),
        .b_i        (op2_sh),
        .fl_i       (fl_cur),
        .sh_carry_i (sh_c),
        .res_o      (result_o),
        .fl_o       (fl_alu)
    );

    always_comb begin
        cmp_op        = is_compare(op);
        upd           = pass && (s_bit_i || cmp_op);
        wr_en_o       = pass && !cmp_op;
        flags_o       = upd ? fl_alu : fl_cur;
        shift_carry_o = sh_c;
    end

    always_comb begin
        if (cmp_op)
            assert_cmp_no_write_R9: assert (!wr_en_o)
                else $error("compare op wrote result");
        if (!pass)
            assert_fail_holds_R10: assert (!wr_en_o && flags_o == flags_i)
                else $error("failed condition had effect");
        if (!s_bit_i && !cmp_op)
            assert_no_s_hold_R11: assert (flags_o == flags_i)
                else $error("flags changed without set-flags");
        if (pass && s_bit_i && !is_arith(op))
            assert_logic_v_keep_R8: assert (flags_o[0] == flags_i[0] && flags_o[1] == shift_carry_o)
                else $error("logic op flag C/V wrong");
    end

endmodule

// File: tb/dp_exec_unit_tb.sv
module dp_exec_unit_tb;
    localparam int W = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]   op, cond, fl_in;
    logic         s_bit, imm_sel, amt_sel;
    logic [W-1:0] a, b;
    logic [7:0]   imm, amt_reg;
    logic [2:0]   kind;
    logic [4:0]   amt_imm;
    logic [W-1:0] result;
    logic         wr_en, shc;
    logic [3:0]   fl_out;

    dp_exec_unit u_dut (
        .op_i(op), .cond_i(cond), .s_bit_i(s_bit), .op1_i(a), .op2_reg_i(b),
        .imm_i(imm), .imm_sel_i(imm_sel), .shift_kind_i(kind),
        .shamt_imm_i(amt_imm), .shamt_reg_i(amt_reg), .shamt_sel_i(amt_sel),
        .flags_i(fl_in), .result_o(result), .wr_en_o(wr_en),
        .flags_o(fl_out), .shift_carry_o(shc)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] res;
        logic         we;
        logic [3:0]   fl;
        logic         sc;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    logic [3:0] last_fl;

    function automatic void ref_shift(input logic [W-1:0] v_in, input logic [2:0] k,
                                      input int n, input logic cin,
                                      output logic [W-1:0] v, output logic c);
        v = v_in;
        c = cin;
        if (k == 3'd4) begin
            c = v_in[0];
            v = {cin, v_in[W-1:1]};
        end else if (k <= 3'd3) begin
            for (int i = 0; i < n; i++) begin
                case (k)
                    3'd0: begin c = v[W-1]; v = v << 1; end
                    3'd1: begin c = v[0]; v = v >> 1; end
                    3'd2: begin c = v[0]; v = {v[W-1], v[W-1:1]}; end
                    default: begin c = v[0]; v = {v[0], v[W-1:1]}; end
                endcase
            end
        end
    endfunction

    function automatic logic ref_cond(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, vv;
        {n, z, c, vv} = f;
        case (cc)
            4'd0: return z;            4'd1: return !z;
            4'd2: return c;            4'd3: return !c;
            4'd4: return n;            4'd5: return !n;
            4'd6: return vv;           4'd7: return !vv;
            4'd8: return c && !z;      4'd9: return !c || z;
            4'd10: return n == vv;     4'd11: return n != vv;
            4'd12: return !z && n == vv; 4'd13: return z || n != vv;
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input string tag, input logic [3:0] o, input logic [3:0] cc,
                         input logic s, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [7:0] im, input logic isel, input logic [2:0] k,
                         input logic [4:0] ai, input logic [7:0] ar, input logic asel,
                         input logic [3:0] f);
        exp_t e;
        logic [W-1:0] b2, r;
        logic sc, cin, pass, cmp, arith;
        longint ua, ub, u, sa, sb, sv;
        logic [3:0] nf;
        cin = f[1];
        ref_shift(isel ? {24'd0, im} : y, k, asel ? int'(ar) : int'(ai), cin, b2, sc);
        ua = longint'(x);  ub = longint'(b2);
        sa = longint'($signed(x)); sb = longint'($signed(b2));
        arith = 1'b1; u = 0; sv = 0;
        case (o)
            4'd6, 4'd15: begin u = ua + ub; sv = sa + sb; end
            4'd7:  begin u = ua + ub + cin; sv = sa + sb + cin; end
            4'd8, 4'd14: begin u = ua - ub; sv = sa - sb; end
            4'd9:  begin u = ua - ub - (1 - cin); sv = sa - sb - (1 - cin); end
            4'd10: begin u = ub - ua; sv = sb - sa; end
            4'd11: begin u = ub - ua - (1 - cin); sv = sb - sa - (1 - cin); end
            default: arith = 1'b0;
        endcase
        case (o)
            4'd0, 4'd12: r = x & b2;
            4'd1, 4'd13: r = x ^ b2;
            4'd2: r = x | b2;
            4'd3: r = x & ~b2;
            4'd4: r = b2;
            4'd5: r = ~b2;
            default: r = u[W-1:0];
        endcase
        nf[3] = r[W-1];
        nf[2] = (r == 0);
        if (arith) begin
            if (o inside {4'd6, 4'd7, 4'd15}) nf[1] = (u >= 64'sh1_0000_0000);
            else                              nf[1] = (u >= 0);
            nf[0] = (sv > 64'sh7fff_ffff) || (sv < -64'sh8000_0000);
        end else begin
            nf[1] = sc;
            nf[0] = f[0];
        end
        pass = ref_cond(cc, f);
        cmp  = (o >= 4'd12);
        e.tag = tag;
        e.res = r;
        e.we  = pass && !cmp;
        e.fl  = (pass && (s || cmp)) ? nf : f;
        e.sc  = sc;
        last_fl = e.fl;
        @(posedge clk);
        #1;
        op = o; cond = cc; s_bit = s; a = x; b = y; imm = im; imm_sel = isel;
        kind = k; amt_imm = ai; amt_reg = ar; amt_sel = asel; fl_in = f;
        q.push_back(e);
    endtask

    // monitor: compare one expected item per cycle
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if ((e.we && result !== e.res) || wr_en !== e.we ||
                    fl_out !== e.fl || shc !== e.sc) begin
                    bad++;
                    $display("FAIL %s: res=%h we=%b fl=%b sc=%b expected res=%h we=%b fl=%b sc=%b",
                             e.tag, result, wr_en, fl_out, shc, e.res, e.we, e.fl, e.sc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] chain_fl;
        op = 0; cond = 4'd14; s_bit = 0; a = 0; b = 0; imm = 0; imm_sel = 0;
        kind = 0; amt_imm = 0; amt_reg = 0; amt_sel = 0; fl_in = 0;
        repeat (2) @(posedge clk);
        // idle pattern, R6 zero AND sets Z
        drive("R6 idle AND", 4'd0, 4'd14, 1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000);
        // R1 immediate operand and R5 arithmetic
        drive("R1 R5 ADD imm", 4'd6, 4'd14, 1, 32'd5, 32'hdead, 8'd3, 1, 0, 0, 0, 0, 4'b0000);
        drive("R5 ADC", 4'd7, 4'd14, 1, 32'd10, 32'd20, 0, 0, 0, 0, 0, 0, 4'b0010);
        drive("R5 R7 SUB neg", 4'd8, 4'd14, 1, 32'd3, 32'd5, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R5 SBC", 4'd9, 4'd14, 1, 32'd100, 32'd40, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R5 RSB", 4'd10, 4'd14, 1, 32'd7, 32'd50, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R5 RSC", 4'd11, 4'd14, 1, 32'd7, 32'd50, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R7 ADD overflow", 4'd6, 4'd14, 1, 32'h7fffffff, 32'd1, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R7 SUB overflow", 4'd8, 4'd14, 1, 32'h80000000, 32'd1, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R7 ADD carry zero", 4'd6, 4'd14, 1, 32'hffffffff, 32'd1, 0, 0, 0, 0, 0, 0, 4'b0000);
        // R6 logic ops
        drive("R6 EOR", 4'd1, 4'd14, 0, 32'hf0f0f0f0, 32'hff00ff00, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R6 ORR", 4'd2, 4'd14, 0, 32'h0000f000, 32'h0000000f, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R6 BIC", 4'd3, 4'd14, 0, 32'hffffffff, 32'h000000f0, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R6 MVN", 4'd5, 4'd14, 1, 0, 32'h0, 0, 0, 0, 0, 0, 0, 4'b0001);
        // R2 R4 shifts
        drive("R2 R4 LSL imm3", 4'd4, 4'd14, 1, 0, 32'hA0000001, 0, 0, 3'd0, 5'd3, 0, 0, 4'b0000);
        drive("R2 LSL zero amt", 4'd4, 4'd14, 1, 0, 32'h12345678, 0, 0, 3'd0, 0, 0, 0, 4'b0010);
        drive("R2 R4 LSL reg32", 4'd4, 4'd14, 1, 0, 32'h00000001, 0, 0, 3'd0, 5'd7, 8'd32, 1, 4'b0000);
        drive("R2 LSL reg33", 4'd4, 4'd14, 1, 0, 32'hffffffff, 0, 0, 3'd0, 0, 8'd33, 1, 4'b0010);
        drive("R2 LSR imm4", 4'd4, 4'd14, 1, 0, 32'h0000001f, 0, 0, 3'd1, 5'd4, 0, 0, 4'b0000);
        drive("R2 LSR reg32", 4'd4, 4'd14, 1, 0, 32'h80000000, 0, 0, 3'd1, 0, 8'd32, 1, 4'b0000);
        drive("R2 LSR reg40", 4'd4, 4'd14, 1, 0, 32'hffffffff, 0, 0, 3'd1, 0, 8'd40, 1, 4'b0000);
        drive("R2 ASR imm8", 4'd4, 4'd14, 1, 0, 32'h80000080, 0, 0, 3'd2, 5'd8, 0, 0, 4'b0000);
        drive("R2 ASR reg33", 4'd4, 4'd14, 1, 0, 32'h90000000, 0, 0, 3'd2, 0, 8'd33, 1, 4'b0000);
        drive("R1 R2 imm LSL", 4'd6, 4'd14, 0, 32'd1, 0, 8'hff, 1, 3'd0, 5'd4, 0, 0, 4'b0000);
        // R3 rotation
        drive("R3 ROR imm8", 4'd4, 4'd14, 1, 0, 32'h000000ab, 0, 0, 3'd3, 5'd8, 0, 0, 4'b0000);
        drive("R3 ROR reg32", 4'd4, 4'd14, 1, 0, 32'h80000001, 0, 0, 3'd3, 0, 8'd32, 1, 4'b0000);
        drive("R3 ROR reg36", 4'd4, 4'd14, 1, 0, 32'h0000000f, 0, 0, 3'd3, 0, 8'd36, 1, 4'b0000);
        drive("R3 RRX", 4'd4, 4'd14, 1, 0, 32'h00000003, 0, 0, 3'd4, 5'd9, 0, 0, 4'b0010);
        // R8 logic flags: C from shifter, V kept
        drive("R8 AND lsr carry", 4'd0, 4'd14, 1, 32'hffffffff, 32'h3, 0, 0, 3'd1, 5'd1, 0, 0, 4'b0001);
        drive("R8 ORR keep V", 4'd2, 4'd14, 1, 32'h1, 32'h2, 0, 0, 3'd0, 5'd1, 0, 0, 4'b0011);
        // R9 compare ops
        drive("R9 CMP s0", 4'd14, 4'd14, 0, 32'd5, 32'd5, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R9 CMP lt", 4'd14, 4'd14, 0, 32'd4, 32'd9, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R9 CMN", 4'd15, 4'd14, 0, 32'hffffffff, 32'd1, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R9 TST", 4'd12, 4'd14, 0, 32'h0f, 32'hf0, 0, 0, 0, 0, 0, 0, 4'b1001);
        drive("R9 TEQ", 4'd13, 4'd14, 0, 32'h80000000, 32'h0, 0, 0, 0, 0, 0, 0, 4'b0000);
        drive("R9 CMP cond fail", 4'd14, 4'd0, 0, 32'd5, 32'd5, 0, 0, 0, 0, 0, 0, 4'b0000);
        // R10 every condition against several flag sets
        for (int cc = 0; cc < 16; cc++) begin
            for (int fv = 0; fv < 16; fv += 5) begin
                drive("R10 cond sweep", 4'd6, 4'(cc), 1, 32'h80000000, 32'h80000000,
                      0, 0, 0, 0, 0, 0, 4'(fv));
            end
        end
        // R11 set-flags clear
        drive("R11 ADD s0", 4'd6, 4'd14, 0, 32'hffffffff, 32'd1, 0, 0, 0, 0, 0, 0, 4'b1001);
        drive("R11 MOV s0", 4'd4, 4'd14, 0, 0, 32'h0, 0, 0, 3'd1, 5'd1, 0, 0, 4'b0100);
        // R12 64-bit chain: low ADD sets flags, high ADC consumes them
        drive("R12 chain low", 4'd6, 4'd14, 1, 32'hffffffff, 32'h00000001, 0, 0, 0, 0, 0, 0, 4'b0000);
        chain_fl = last_fl;
        drive("R12 chain high", 4'd7, 4'd14, 1, 32'h00000001, 32'h00000002, 0, 0, 0, 0, 0, 0, chain_fl);
        if (chain_fl[1] !== 1'b1) begin
            bad++;
            $display("FAIL R12 low carry=%b expected 1", chain_fl[1]);
        end
        total++;
        // R13 shifter carry visible on a failed condition
        drive("R13 carry on fail", 4'd4, 4'd15, 1, 0, 32'h00000001, 0, 0, 3'd1, 5'd1, 0, 0, 4'b0000);
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule